// File: doc/BRIEF.md
# Sync and Clock Output Selector

This block holds two small control registers on a generic synchronous register bus. It uses their contents to steer two output pins. The composite/horizontal sync pin picks one of several internal video timing signals, or a constant low. The buffered clock pin also picks a timing signal, then applies a selectable inversion and a tri-state enable. The tri-state pin is modelled as a value plus an output-enable, so that the pad cell can sit elsewhere in the chip.

The first register also carries a bypass flag and two gain bits for the converter datapath. When the bypass flag is set, raw pixel data goes straight to the three converter channels. When it is clear, the channels take the data produced by the encoder path. The two gain bits are exported unchanged for downstream logic.

Register writes land on the clock edge that samples the write strobe. Every output multiplexer is combinational from the current register contents. The read data port is combinational from the address.

Top module: `sync_clkout_sel`

## Requirements
- R1: After reset, both registers read 0x00, `chs_out` is 0 and `clkbuf_oe` is 0.
- R2: A write to address 0x21 stores bits 4:0 on the sampling edge, and the old value is still read before that edge. Field positions: bit 0 is bypass, bits 2:1 are gain (bit 1 = `dac_gain[0]`), and bits 4:3 are the sync select.
- R3: A write to address 0x22 stores bits 4:0. Field positions: bits 2:0 are the clock select, bit 3 is polarity and bit 4 is enable. Bits 7:5 of both registers read 0 whatever was written.
- R4: Reads from any address other than 0x21 or 0x22 return 0x00. Writes to such addresses change neither register.
- R5: Sync select code 01 routes `vga_hsync` to `chs_out`. Codes 00, 10 and 11 drive 0, and `tv_csync` and `tv_hsync` have no effect.
- R6: Clock select code 110 routes `vga_vsync`. Every other code gives 0 before polarity is applied.
- R7: When polarity is 1, `clkbuf_out` equals the selected value. When polarity is 0, it is the inverse.
- R8: `clkbuf_oe` equals the enable bit. With enable 0 the pin is high impedance.
- R9: With bypass 1, `dac_data_out` equals `pix_in`. With bypass 0, it equals `enc_in`.
- R10: `dac_gain` mirrors register bits 2:1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from address |
| vga_hsync | input | 1 | Monitor horizontal sync |
| vga_vsync | input | 1 | Monitor vertical sync |
| tv_csync | input | 1 | TV composite sync |
| tv_hsync | input | 1 | TV horizontal sync |
| pix_in | input | CH_N*CH_W | Raw pixel data |
| enc_in | input | CH_N*CH_W | Encoder datapath data |
| dac_data_out | output | CH_N*CH_W | Data to the converter channels |
| dac_bypass | output | 1 | Bypass flag |
| dac_gain | output | 2 | Gain control bits |
| chs_out | output | 1 | Composite/horizontal sync pin value |
| clkbuf_out | output | 1 | Buffered clock pin value |
| clkbuf_oe | output | 1 | Buffered clock pin output enable |

## Verification
On every cycle, the bound assertions check the following: that the pin values follow the select codes and polarity, that reserved and unmapped reads stay zero, that register fields move only on a mapped write, and that the bypass path is followed. The bench alone shows the reset values and the exact edge on which a write takes effect. It also sweeps every select, polarity and enable combination against both levels of the timing inputs, and confirms that a write to any of the 254 unmapped addresses leaves both registers intact.

// File: rtl/sco_pkg.sv
// Package: register addresses, field layouts and selection masks shared by
// the sync/clock output selector. Assumes registers are at most 8 bits wide.
package sco_pkg;
    localparam logic [7:0] ADDR_DAC   = 8'h21;
    localparam logic [7:0] ADDR_CLK   = 8'h22;
    localparam int         FIELD_W    = 5;
    localparam int         SYNC_SEL_W = 2;
    localparam int         CLK_SEL_W  = 3;
    // one bit per select code: 1 = valid selection
    localparam logic [(1<<SYNC_SEL_W)-1:0] SYNC_VALID = 4'b0010;
    localparam logic [(1<<CLK_SEL_W)-1:0]  CLK_VALID  = 8'b0100_0000;

    typedef struct packed {
        logic [SYNC_SEL_W-1:0] sync_sel;  // bits 4:3
        logic [1:0]            gain;      // bits 2:1
        logic                  bypass;    // bit 0
    } dac_cfg_t;

    typedef struct packed {
        logic                 en;         // bit 4
        logic                 pol;        // bit 3
        logic [CLK_SEL_W-1:0] sel;        // bits 2:0
    } clk_cfg_t;
endpackage

// File: rtl/sco_ctl_regs.sv
// Register bank: two 5-bit control registers with zero-filled reserved bits.
// Assumes DATA_W >= FIELD_W and ADDR_W >= 8; unmapped reads return zero.
module sco_ctl_regs
    import sco_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output dac_cfg_t          dac_cfg,
    output clk_cfg_t          clk_cfg
);
    localparam logic [ADDR_W-1:0] A_DAC = ADDR_W'(ADDR_DAC);
    localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(ADDR_CLK);

    dac_cfg_t dac_q;
    clk_cfg_t clk_q;

    // Capture implemented bits on a write to a mapped address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= '0;
            clk_q <= '0;
        end else if (wr) begin
            if (addr == A_DAC) dac_q <= dac_cfg_t'(wdata[FIELD_W-1:0]);
            if (addr == A_CLK) clk_q <= clk_cfg_t'(wdata[FIELD_W-1:0]);
        end
    end

    // Return the addressed register with reserved bits zero.
    always_comb begin
        rdata = '0;
        if (addr == A_DAC)      rdata = DATA_W'(dac_q);
        else if (addr == A_CLK) rdata = DATA_W'(clk_q);
    end

    assign dac_cfg = dac_q;
    assign clk_cfg = clk_q;
endmodule

// File: rtl/sco_src_mux.sv
// Masked selector: routes src[sel] when the code is marked valid, else 0.
// Assumes src holds one lane per select code.
module sco_src_mux #(
    parameter int SEL_W = 2,
    parameter logic [(1<<SEL_W)-1:0] VALID = '0
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [(1<<SEL_W)-1:0] src,
    output logic                  out
);
    // Pick the lane and blank it when its code is not a valid selection.
    always_comb out = VALID[sel] & src[sel];
endmodule

// File: rtl/sco_pad_drv.sv
// Pad model: optional inversion plus an output enable for a tri-state pin.
// Assumes the real pad cell is instantiated outside this block.
module sco_pad_drv (
    input  logic sig,
    input  logic pol,
    input  logic en,
    output logic out,
    output logic oe
);
    // Polarity 1 passes the signal; 0 inverts it.
    always_comb out = pol ? sig : ~sig;
    assign oe = en;
endmodule

// File: rtl/sco_dac_route.sv
// Per-channel selection between raw pixel data and encoder data.
// Assumes channels are packed with channel 0 in the low bits.
module sco_dac_route #(
    parameter int CH_N = 3,
    parameter int CH_W = 10
) (
    input  logic                 bypass,
    input  logic [CH_N*CH_W-1:0] pix_in,
    input  logic [CH_N*CH_W-1:0] enc_in,
    output logic [CH_N*CH_W-1:0] dac_out
);
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        // One channel: raw data when bypassed, encoder data otherwise.
        assign dac_out[c*CH_W +: CH_W] = bypass ? pix_in[c*CH_W +: CH_W]
                                                : enc_in[c*CH_W +: CH_W];
    end
endmodule

// File: rtl/sync_clkout_sel.sv
// Top: register bank steering the sync pin, the buffered clock pin and the
// converter datapath. Timing lanes: 0 tv_hsync, 1 vga_hsync, 2 vga_vsync,
// 3 tv_csync; mux inputs repeat these lanes and the valid masks blank
// every code that is not a legal selection.
module sync_clkout_sel
    import sco_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CH_N   = 3,
    parameter int CH_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 vga_hsync,
    input  logic                 vga_vsync,
    input  logic                 tv_csync,
    input  logic                 tv_hsync,
    input  logic [CH_N*CH_W-1:0] pix_in,
    input  logic [CH_N*CH_W-1:0] enc_in,
    output logic [CH_N*CH_W-1:0] dac_data_out,
    output logic                 dac_bypass,
    output logic [1:0]           dac_gain,
    output logic                 chs_out,
    output logic                 clkbuf_out,
    output logic                 clkbuf_oe
);
    localparam int N_SYNC = 1 << SYNC_SEL_W;
    localparam int N_CLK  = 1 << CLK_SEL_W;

    dac_cfg_t dac_cfg;
    clk_cfg_t clk_cfg;
    logic [SYNC_SEL_W-1:0] sync_sel;
    logic [CLK_SEL_W-1:0]  clk_sel;
    logic                  clk_pol;
    logic                  clk_en;
    logic [3:0]            lanes;
    logic [N_SYNC-1:0]     sync_src;
    logic [N_CLK-1:0]      clk_src;
    logic                  clk_raw;

    sco_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .dac_cfg(dac_cfg), .clk_cfg(clk_cfg)
    );

    assign sync_sel   = dac_cfg.sync_sel;
    assign clk_sel    = clk_cfg.sel;
    assign clk_pol    = clk_cfg.pol;
    assign clk_en     = clk_cfg.en;
    assign dac_bypass = dac_cfg.bypass;
    assign dac_gain   = dac_cfg.gain;
    assign lanes      = {tv_csync, vga_vsync, vga_hsync, tv_hsync};

    for (genvar k = 0; k < N_SYNC; k++) begin : g_sync_src
        assign sync_src[k] = lanes[k % 4];
    end
    for (genvar k = 0; k < N_CLK; k++) begin : g_clk_src
        assign clk_src[k] = lanes[k % 4];
    end

    sco_src_mux #(.SEL_W(SYNC_SEL_W), .VALID(SYNC_VALID)) sync_mux_i (
        .sel(sync_sel), .src(sync_src), .out(chs_out)
    );

    sco_src_mux #(.SEL_W(CLK_SEL_W), .VALID(CLK_VALID)) clk_mux_i (
        .sel(clk_sel), .src(clk_src), .out(clk_raw)
    );

    sco_pad_drv pad_i (
        .sig(clk_raw), .pol(clk_pol), .en(clk_en),
        .out(clkbuf_out), .oe(clkbuf_oe)
    );

    sco_dac_route #(.CH_N(CH_N), .CH_W(CH_W)) dac_i (
        .bypass(dac_bypass), .pix_in(pix_in), .enc_in(enc_in),
        .dac_out(dac_data_out)
    );
endmodule

// File: rtl/sco_chk.sv
// Checker for sync_clkout_sel: pin routing, register update and read rules.
// Assumes the default 8-bit data and address widths of the register bus.
module sco_chk
    import sco_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CH_N   = 3,
    parameter int CH_W   = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_wr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 vga_hsync,
    input logic                 vga_vsync,
    input logic [CH_N*CH_W-1:0] pix_in,
    input logic [CH_N*CH_W-1:0] dac_data_out,
    input logic                 dac_bypass,
    input logic [1:0]           dac_gain,
    input logic                 chs_out,
    input logic                 clkbuf_out,
    input logic [SYNC_SEL_W-1:0] sync_sel,
    input logic [CLK_SEL_W-1:0]  clk_sel,
    input logic                 clk_pol,
    input logic                 clk_en
);
    logic hit_dac, hit_clk;
    assign hit_dac = (reg_addr == ADDR_W'(ADDR_DAC));
    assign hit_clk = (reg_addr == ADDR_W'(ADDR_CLK));

    p_wr_dac_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_dac) |=> (dac_bypass == $past(reg_wdata[0]) &&
            dac_gain == $past(reg_wdata[2:1]) && sync_sel == $past(reg_wdata[4:3])));

    p_resv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dac || hit_clk) |-> (reg_rdata[DATA_W-1:FIELD_W] == '0));

    p_unmapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_dac || hit_clk) |-> (reg_rdata == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (hit_dac || hit_clk)) |=> ($stable(dac_bypass) &&
            $stable(dac_gain) && $stable(sync_sel) && $stable(clk_sel) &&
            $stable(clk_pol) && $stable(clk_en)));

    p_chs_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_sel != 2'b01) |-> !chs_out);

    p_chs_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_sel == 2'b01) |-> (chs_out == vga_hsync));

    p_clk_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != 3'b110) |-> (clkbuf_out == !clk_pol));

    p_clk_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b110) |-> (clkbuf_out == (clk_pol ? vga_vsync : !vga_vsync)));

    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dac_bypass |-> (dac_data_out == pix_in));
endmodule

bind sync_clkout_sel sco_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_N(CH_N), .CH_W(CH_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vga_hsync(vga_hsync), .vga_vsync(vga_vsync),
    .pix_in(pix_in), .dac_data_out(dac_data_out),
    .dac_bypass(dac_bypass), .dac_gain(dac_gain),
    .chs_out(chs_out), .clkbuf_out(clkbuf_out),
    .sync_sel(sync_sel), .clk_sel(clk_sel), .clk_pol(clk_pol), .clk_en(clk_en)
);

// File: tb/sync_clkout_sel_tb_top.sv
`timescale 1ns/1ps
// Bench: exhaustive sweeps of both registers, of the timing inputs and of
// the unmapped address space, with expected values computed from the
// requirements.
module sync_clkout_sel_tb_top;
    localparam int CH_N = 3;
    localparam int CH_W = 10;
    localparam int PW   = CH_N * CH_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          vga_hsync = 0, vga_vsync = 0, tv_csync = 0, tv_hsync = 0;
    logic [PW-1:0] pix_in = 30'h2AA_1555;
    logic [PW-1:0] enc_in = 30'h1555_2AA;
    logic [PW-1:0] dac_data_out;
    logic          dac_bypass, chs_out, clkbuf_out, clkbuf_oe;
    logic [1:0]    dac_gain;
    int            n_chk = 0, n_bad = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    sync_clkout_sel #(.CH_N(CH_N), .CH_W(CH_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vga_hsync(vga_hsync), .vga_vsync(vga_vsync),
        .tv_csync(tv_csync), .tv_hsync(tv_hsync),
        .pix_in(pix_in), .enc_in(enc_in), .dac_data_out(dac_data_out),
        .dac_bypass(dac_bypass), .dac_gain(dac_gain), .chs_out(chs_out),
        .clkbuf_out(clkbuf_out), .clkbuf_oe(clkbuf_oe)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, req, 32'(reg_rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        rd_chk(8'h21, 8'h00, "R1 dac reg");
        rd_chk(8'h22, 8'h00, "R1 clk reg");
        chk(chs_out === 1'b0, "R1 chs_out", 32'(chs_out), 0);
        chk(clkbuf_oe === 1'b0, "R1 clkbuf_oe", 32'(clkbuf_oe), 0);

        // R2: write not visible before the sampling edge
        @(negedge clk);
        reg_addr = 8'h21; reg_wdata = 8'h1F; reg_wr = 1'b1;
        #1;
        chk(reg_rdata === 8'h00, "R2 before edge", 32'(reg_rdata), 0);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
        chk(reg_rdata === 8'h1F, "R2 after edge", 32'(reg_rdata), 32'h1F);

        // Sweep of the first register: R2 R3 R5 R9 R10
        for (int k = 0; k < 32; k++) begin
            logic [7:0] v;
            v = {3'b101, 5'(k)};
            wr(8'h21, v);
            rd_chk(8'h21, v & 8'h1F, "R2/R3 dac readback");
            chk(dac_bypass === v[0], "R2 bypass", 32'(dac_bypass), 32'(v[0]));
            chk(dac_gain === v[2:1], "R10 gain", 32'(dac_gain), 32'(v[2:1]));
            chk(dac_data_out === (v[0] ? pix_in : enc_in), "R9 dac data",
                32'(dac_data_out), 32'(v[0] ? pix_in : enc_in));
            for (int h = 0; h < 4; h++) begin
                logic e;
                vga_hsync = h[0]; tv_csync = ~h[0]; tv_hsync = ~h[0]; vga_vsync = h[1];
                #1;
                e = (v[4:3] == 2'b01) ? h[0] : 1'b0;
                chk(chs_out === e, "R5 chs_out", 32'(chs_out), 32'(e));
            end
        end

        // Sweep of the second register: R3 R6 R7 R8
        for (int k = 0; k < 32; k++) begin
            logic [7:0] v;
            v = {3'b111, 5'(k)};
            wr(8'h22, v);
            rd_chk(8'h22, v & 8'h1F, "R3 clk readback");
            chk(clkbuf_oe === v[4], "R8 oe", 32'(clkbuf_oe), 32'(v[4]));
            for (int s = 0; s < 4; s++) begin
                logic raw, e;
                vga_vsync = s[0]; vga_hsync = s[1]; tv_csync = ~s[0]; tv_hsync = s[1];
                #1;
                raw = (v[2:0] == 3'b110) ? s[0] : 1'b0;
                e = v[3] ? raw : ~raw;
                chk(clkbuf_out === e, "R6/R7 clkbuf_out", 32'(clkbuf_out), 32'(e));
            end
        end

        // R4: unmapped addresses read zero and leave both registers intact
        wr(8'h21, 8'h0A);
        wr(8'h22, 8'h15);
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h21 && a != 8'h22) begin
                wr(8'(a), 8'hFF);
                rd_chk(8'(a), 8'h00, "R4 unmapped read");
            end
        end
        rd_chk(8'h21, 8'h0A, "R4 dac reg intact");
        rd_chk(8'h22, 8'h15, "R4 clk reg intact");

        // R1: reset returns to the initial state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(8'h21, 8'h00, "R1 dac reg after reset");
        rd_chk(8'h22, 8'h00, "R1 clk reg after reset");
        chk(clkbuf_oe === 1'b0, "R1 oe after reset", 32'(clkbuf_oe), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule